// File: doc/BRIEF.md
# Dynamic Tamper Pin Pair Checker

This block guards three pairs of tamper pins. On one pin of each pair it drives a bit stream taken from a pseudo-random pattern, and it checks that the partner pin returns the same value. Pair 0 drives `drive_o[0]` and reads `sense_i[0]`, pair 1 drives `drive_o[1]` and reads `sense_i[1]`, and pair 2 drives `drive_o[2]` and reads `sense_i[2]`. A cut, shorted or forced trace makes the returned value differ from the expected one, and the block then reports a tamper event for that pair as a one-cycle pulse. The block runs entirely on the slow tamper clock `clk`.

The pattern is a 32-bit word held in a register. Each output bit is held for a programmable number of clock cycles. When all 32 bits of the word have been sent, the next word comes from a Galois LFSR, or the latched seed is sent again, depending on a policy input. Software starts a reload with a request pulse. The reload latches the seed and the change rate, restarts the pattern, and clears the busy flag by itself once it completes.

Two select inputs allow one drive pin to feed two return traces. When pair 0 is enabled together with pair 1 or with pair 2, that pair can take its expected value from pair 0's drive pin.

Top module: `tamper_dyn_pair`

## Requirements
- R1: After reset, `drive_o`, `event_o` and `reload_busy_o` are all 0. The latched seed and the pattern word both reset to 32'h1D87_2B41 and the latched rate resets to 0.
- R2: A hold period lasts 2^(6+R) cycles, where R is the 3-bit rate latched at the last reload. A hold counter runs from 0 to 2^(6+R)-1, and the bit index moves forward by one when the counter wraps.
- R3: An enabled pair p drives bit ((idx + 10*p) mod 32) of the pattern word, where idx is the bit index. A reload loads the word with the seed, and a seed of 0 is replaced by 32'h1D87_2B41.
- R4: When the counter wraps with idx = 31, idx returns to 0 and a new word is loaded. If `replay_i` is 1, the new word is the latched seed. If `replay_i` is 0, the LFSR state s steps to (s>>1) ^ (s[0] ? 32'h8020_0003 : 0), and the new word is that stepped value. A reload loads the LFSR state with the latched seed.
- R5: A pulse on `reload_req_i` sets `reload_busy_o` at the next clock edge. The reload is performed on the third edge after that one, and at that same edge `reload_busy_o` clears, the counter and idx go to 0, and the seed and rate are latched.
- R6: `pair_en_i` passes through a two-flop synchroniser. A pair whose synchronised enable is 0 drives 0 and never reports an event.
- R7: The comparison takes place once per hold period, when the counter equals 2^(5+R). On a mismatch, `event_o[p]` is high for exactly the following cycle.
- R8: After a reload, comparisons stay masked until the first full hold period has ended.
- R9: When `sel1_i` is 1 and the synchronised enables of pairs 0 and 1 are both 1, pair 1 compares `sense_i[1]` against `drive_o[0]`. Otherwise it compares against `drive_o[1]`.
- R10: When `sel2_i` is 1 and the synchronised enables of pairs 0 and 2 are both 1, pair 2 compares `sense_i[2]` against `drive_o[0]`. Otherwise it compares against `drive_o[2]`.
- R11: A change on `rate_i` or `seed_i` has no effect until the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow tamper clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seed_i | input | 32 | Seed, latched on reload |
| rate_i | input | 3 | Change rate R, latched on reload |
| replay_i | input | 1 | Refill policy: 1 replays the seed, 0 steps the LFSR |
| reload_req_i | input | 1 | One-cycle reload request |
| pair_en_i | input | 3 | Dynamic detection enable, one bit per pair |
| sel1_i | input | 1 | Pair 1 expects pair 0's drive |
| sel2_i | input | 1 | Pair 2 expects pair 0's drive |
| sense_i | input | 3 | Return pins, one bit per pair |
| drive_o | output | 3 | Drive pins, one bit per pair |
| event_o | output | 3 | One-cycle tamper event pulse, one bit per pair |
| reload_busy_o | output | 1 | Self-clearing reload-in-progress flag |

## Verification
The latency of each result is fixed. `reload_busy_o` rises one edge after the request and falls on the fourth edge. A synchronised enable reaches `drive_o` two edges after it is applied. A drive bit changes on the edge that ends a hold period. An event pulse appears on the edge after the comparison count. The bench holds a behavioural model that advances on each rising edge using the inputs present before that edge. It compares every output on the falling edge that follows, and directed counts over whole hold periods confirm the masking, select and disable cases.

// File: rtl/tdp_pkg.sv
package tdp_pkg;
  localparam int unsigned    PAT_W        = 32;
  localparam int unsigned    NPAIR        = 3;
  localparam int unsigned    RATE_W       = 3;
  localparam logic [31:0]    SEED_DEFAULT = 32'h1D87_2B41;
  localparam logic [31:0]    LFSR_TAPS    = 32'h8020_0003;

  typedef enum logic {
    REFILL_PRNG   = 1'b0,
    REFILL_REPLAY = 1'b1
  } refill_e;
endpackage

// File: rtl/tdp_sync.sv
module tdp_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/tdp_reload_ctrl.sv
module tdp_reload_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic busy_o,
  output logic load_o
);
  logic busy_q, busy_d;
  logic s1_q, s1_d;
  logic s2_q, s2_d;

  assign load_o = busy_q & s2_q;

  always_comb begin
    busy_d = req_i | (busy_q & ~load_o);
    s1_d   = load_o ? 1'b0 : busy_q;
    s2_d   = load_o ? 1'b0 : s1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
    end else begin
      busy_q <= busy_d;
      s1_q   <= s1_d;
      s2_q   <= s2_d;
    end
  end

  assign busy_o = busy_q;

  // R5: the flag drops after the load unless a new request arrives
  a_r5_clear_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    (load_o && !req_i) |=> !busy_o);
  // R5: the flag holds until the load
  a_r5_hold_until_load: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !load_o) |=> busy_o);
endmodule

// File: rtl/tdp_pattern_gen.sv
module tdp_pattern_gen
  import tdp_pkg::*;
#(
  parameter int unsigned BASE_EXP = 6,
  parameter int unsigned W        = 32,
  parameter int unsigned NP       = 3,
  parameter int unsigned RW       = 3,
  parameter int unsigned STRIDE   = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [W-1:0]  seed_i,
  input  logic [RW-1:0] rate_i,
  input  logic          replay_i,
  input  logic [NP-1:0] en_i,
  output logic [NP-1:0] drive_o,
  output logic          strobe_o
);
  localparam int unsigned RATE_SPAN = (1 << RW) - 1;
  localparam int unsigned CNT_W     = BASE_EXP + RATE_SPAN;
  localparam int unsigned IDX_W     = $clog2(W);
  localparam logic [W-1:0] TAPS     = W'(LFSR_TAPS);
  localparam logic [W-1:0] FALLBACK = W'(SEED_DEFAULT);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [W-1:0]     word_q, word_d;
  logic [W-1:0]     lfsr_q, lfsr_d;
  logic [W-1:0]     seed_q, seed_d;
  logic [RW-1:0]    rate_q, rate_d;
  logic             armed_q, armed_d;

  logic [CNT_W-1:0] last_c;
  logic [CNT_W-1:0] half_c;
  logic             at_end;
  logic             at_mid;
  logic             word_done;
  logic [W-1:0]     lfsr_step;
  logic [W-1:0]     seed_fix;
  refill_e          policy;

  assign last_c    = {CNT_W{1'b1}} >> (RATE_SPAN - 32'(rate_q));
  assign half_c    = last_c ^ (last_c >> 1);
  assign at_end    = (cnt_q == last_c);
  assign at_mid    = (cnt_q == half_c);
  assign word_done = (idx_q == {IDX_W{1'b1}});
  assign lfsr_step = lfsr_q[0] ? ((lfsr_q >> 1) ^ TAPS) : (lfsr_q >> 1);
  assign seed_fix  = (seed_i == '0) ? FALLBACK : seed_i;
  assign policy    = replay_i ? REFILL_REPLAY : REFILL_PRNG;

  always_comb begin
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    word_d  = word_q;
    lfsr_d  = lfsr_q;
    seed_d  = seed_q;
    rate_d  = rate_q;
    armed_d = armed_q;
    if (load_i) begin
      cnt_d   = '0;
      idx_d   = '0;
      word_d  = seed_fix;
      lfsr_d  = seed_fix;
      seed_d  = seed_fix;
      rate_d  = rate_i;
      armed_d = 1'b0;
    end else if (at_end) begin
      cnt_d   = '0;
      armed_d = 1'b1;
      idx_d   = idx_q + 1'b1;
      if (word_done) begin
        unique case (policy)
          REFILL_REPLAY: word_d = seed_q;
          REFILL_PRNG: begin
            lfsr_d = lfsr_step;
            word_d = lfsr_step;
          end
        endcase
      end
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      idx_q   <= '0;
      word_q  <= FALLBACK;
      lfsr_q  <= FALLBACK;
      seed_q  <= FALLBACK;
      rate_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      word_q  <= word_d;
      lfsr_q  <= lfsr_d;
      seed_q  <= seed_d;
      rate_q  <= rate_d;
      armed_q <= armed_d;
    end
  end

  for (genvar p = 0; p < NP; p++) begin : g_drive
    localparam int unsigned OFS = (p * STRIDE) % W;
    logic [IDX_W-1:0] pos;
    assign pos        = idx_q + IDX_W'(OFS);
    assign drive_o[p] = en_i[p] & word_q[pos];
  end

  assign strobe_o = at_mid & armed_q;

  // R2: the bit index only moves at the end of a hold period or on a load
  a_r2_idx_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !at_end) |=> $stable(idx_q));
  // R3, R4: the pattern word is never all zero
  a_r3_word_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    word_q != '0);
  // R11: the latched rate only changes on a load
  a_r11_rate_latched: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(rate_q));
endmodule

// File: rtl/tdp_pair_cmp.sv
module tdp_pair_cmp #(
  parameter int unsigned NP = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NP-1:0] drive_i,
  input  logic [NP-1:0] sense_i,
  input  logic [NP-1:0] en_i,
  input  logic          sel1_i,
  input  logic          sel2_i,
  input  logic          strobe_i,
  output logic [NP-1:0] event_o
);
  logic [NP-1:0] expect_c;
  logic [NP-1:0] event_d;
  logic [NP-1:0] event_q;

  for (genvar p = 0; p < NP; p++) begin : g_pair
    if (p == 1) begin : g_sel1
      assign expect_c[p] = (sel1_i & en_i[0] & en_i[1]) ? drive_i[0] : drive_i[1];
    end else if (p == 2) begin : g_sel2
      assign expect_c[p] = (sel2_i & en_i[0] & en_i[2]) ? drive_i[0] : drive_i[2];
    end else begin : g_plain
      assign expect_c[p] = drive_i[p];
    end

    assign event_d[p] = strobe_i & en_i[p] & (sense_i[p] ^ expect_c[p]);

    // R7: an event lasts one cycle
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      event_q[p] |=> !event_q[p]);
    // R7, R8: an event follows an armed comparison point
    a_r8_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      event_q[p] |-> $past(strobe_i));
    // R6: a disabled pair stays silent
    a_r6_enabled_only: assert property (@(posedge clk) disable iff (!rst_n)
      event_q[p] |-> $past(en_i[p]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) event_q <= '0;
    else        event_q <= event_d;
  end

  assign event_o = event_q;
endmodule

// File: rtl/tamper_dyn_pair.sv
module tamper_dyn_pair
  import tdp_pkg::*;
#(
  parameter int unsigned BASE_EXP = 6,
  parameter int unsigned STRIDE   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PAT_W-1:0]  seed_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              replay_i,
  input  logic              reload_req_i,
  input  logic [NPAIR-1:0]  pair_en_i,
  input  logic              sel1_i,
  input  logic              sel2_i,
  input  logic [NPAIR-1:0]  sense_i,
  output logic [NPAIR-1:0]  drive_o,
  output logic [NPAIR-1:0]  event_o,
  output logic              reload_busy_o
);
  logic [NPAIR-1:0] en_sync;
  logic             load;
  logic             strobe;

  tdp_sync #(.W(NPAIR)) u_en_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pair_en_i),
    .q_o   (en_sync)
  );

  tdp_reload_ctrl u_reload (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (reload_req_i),
    .busy_o (reload_busy_o),
    .load_o (load)
  );

  tdp_pattern_gen #(
    .BASE_EXP (BASE_EXP),
    .W        (PAT_W),
    .NP       (NPAIR),
    .RW       (RATE_W),
    .STRIDE   (STRIDE)
  ) u_pattern (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load),
    .seed_i   (seed_i),
    .rate_i   (rate_i),
    .replay_i (replay_i),
    .en_i     (en_sync),
    .drive_o  (drive_o),
    .strobe_o (strobe)
  );

  tdp_pair_cmp #(.NP(NPAIR)) u_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .drive_i  (drive_o),
    .sense_i  (sense_i),
    .en_i     (en_sync),
    .sel1_i   (sel1_i),
    .sel2_i   (sel2_i),
    .strobe_i (strobe),
    .event_o  (event_o)
  );

  // R6: a pair that is not enabled drives low
  a_r6_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    ((drive_o & ~en_sync) == '0));
endmodule

// File: tb/tamper_dyn_pair_test.sv
module tamper_dyn_pair_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] seed = '0;
  logic [2:0]  rate = '0;
  logic        replay = 1'b0;
  logic        req = 1'b0;
  logic [2:0]  en = '0;
  logic        sel1 = 1'b0;
  logic        sel2 = 1'b0;
  logic [2:0]  fault = '0;
  logic        cross1 = 1'b0;
  logic        cross2 = 1'b0;
  logic [2:0]  sense;
  logic [2:0]  drive;
  logic [2:0]  event_w;
  logic        busy;

  always #5 clk = ~clk;

  assign sense[0] = drive[0] ^ fault[0];
  assign sense[1] = (cross1 ? drive[0] : drive[1]) ^ fault[1];
  assign sense[2] = (cross2 ? drive[0] : drive[2]) ^ fault[2];

  tamper_dyn_pair uut (
    .clk (clk), .rst_n (rst_n), .seed_i (seed), .rate_i (rate),
    .replay_i (replay), .reload_req_i (req), .pair_en_i (en),
    .sel1_i (sel1), .sel2_i (sel2), .sense_i (sense),
    .drive_o (drive), .event_o (event_w), .reload_busy_o (busy)
  );

  int vectors = 0;
  int errors = 0;
  int cycles = 0;
  int evc [3];

  // behavioural reference
  int          m_cnt, m_idx, m_rate;
  logic [31:0] m_word, m_lfsr, m_seed;
  logic        m_armed, m_busy, m_s1, m_s2;
  logic [2:0]  m_en1, m_en2, m_ev, m_dv, m_exp;
  logic        m_ld;
  int          m_hold;

  function automatic logic [2:0] mdrive(logic [2:0] e, logic [31:0] w, int ix);
    logic [2:0] r;
    for (int p = 0; p < 3; p++) r[p] = e[p] & w[(ix + 10*p) % 32];
    return r;
  endfunction

  function automatic logic [31:0] step(logic [31:0] s);
    return s[0] ? ((s >> 1) ^ 32'h8020_0003) : (s >> 1);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_idx = 0; m_rate = 0; m_word = 32'h1D87_2B41;
      m_lfsr = 32'h1D87_2B41; m_seed = 32'h1D87_2B41; m_armed = 0;
      m_busy = 0; m_s1 = 0; m_s2 = 0; m_en1 = 0; m_en2 = 0; m_ev = 0;
    end else begin
      m_hold = 1 << (6 + m_rate);
      m_ld = m_busy & m_s2;
      m_dv = mdrive(m_en2, m_word, m_idx);
      m_exp = m_dv;
      if (sel1 && m_en2[0] && m_en2[1]) m_exp[1] = m_dv[0];
      if (sel2 && m_en2[0] && m_en2[2]) m_exp[2] = m_dv[0];
      for (int p = 0; p < 3; p++)
        m_ev[p] = (m_cnt == m_hold/2) && m_armed && m_en2[p] && (sense[p] != m_exp[p]);
      if (m_ld) begin
        m_seed = (seed == 0) ? 32'h1D87_2B41 : seed;
        m_word = m_seed; m_lfsr = m_seed; m_cnt = 0; m_idx = 0;
        m_rate = int'(rate); m_armed = 0;
      end else if (m_cnt == m_hold - 1) begin
        m_cnt = 0; m_armed = 1;
        if (m_idx == 31) begin
          m_idx = 0;
          if (replay) m_word = m_seed;
          else begin m_lfsr = step(m_lfsr); m_word = m_lfsr; end
        end else m_idx = m_idx + 1;
      end else m_cnt = m_cnt + 1;
      m_s2 = m_ld ? 1'b0 : m_s1;
      m_s1 = m_ld ? 1'b0 : m_busy;
      m_busy = req | (m_busy & ~m_ld);
      m_en2 = m_en1;
      m_en1 = en;
    end
  end

  // cycle-by-cycle comparison
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      vectors++;
      if (drive !== mdrive(m_en2, m_word, m_idx)) begin
        errors++;
        $display("FAIL R2/R3/R4/R11 drive cycle %0d: got %b exp %b", cycles, drive, mdrive(m_en2, m_word, m_idx));
      end
      if (event_w !== m_ev) begin
        errors++;
        $display("FAIL R7/R8/R9/R10 event cycle %0d: got %b exp %b", cycles, event_w, m_ev);
      end
      if (busy !== m_busy) begin
        errors++;
        $display("FAIL R5 busy cycle %0d: got %b exp %b", cycles, busy, m_busy);
      end
      for (int p = 0; p < 3; p++) if (event_w[p]) evc[p]++;
    end
    if (cycles > 190000) begin
      errors++;
      $display("FAIL watchdog: got %0d cycles exp < 190000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d exp %0d", tag, got, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clr_ev();
    for (int p = 0; p < 3; p++) evc[p] = 0;
  endtask

  task automatic reload();
    @(negedge clk) req = 1'b1;
    @(negedge clk) req = 1'b0;
    wait_n(3);
  endtask

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 drive after reset", int'(drive), 0);
    chk("R1 event after reset", int'(event_w), 0);
    chk("R1 busy after reset", int'(busy), 0);

    // R5 handshake timing
    seed = 32'h1234_5678; rate = 3'd0; en = 3'b111;
    @(negedge clk) req = 1'b1;
    @(negedge clk) req = 1'b0;
    chk("R5 busy one edge after request", int'(busy), 1);
    wait_n(2);
    chk("R5 busy still set before load", int'(busy), 1);
    @(negedge clk);
    chk("R5 busy cleared by load", int'(busy), 0);

    // clean loop, fresh PRNG refills: no events
    clr_ev();
    wait_n(4300);
    chk("R7 no event on intact pairs", evc[0] + evc[1] + evc[2], 0);

    // R7 fault on pair 1
    clr_ev();
    fault = 3'b010;
    wait_n(640);
    fault = 3'b000;
    chk("R7 fault on pair 1 reported", int'(evc[1] > 0), 1);
    chk("R7 intact pair 0 silent", evc[0], 0);

    // R4 replay policy across two words
    replay = 1'b1;
    wait_n(4200);
    replay = 1'b0;

    // R11 rate change without reload, then reload with rate 1 (R2)
    rate = 3'd1; seed = 32'hCAFE_F00D;
    wait_n(300);
    reload();
    wait_n(600);

    // R8: fault active across reload, masked during first period
    fault = 3'b001;
    rate = 3'd0;
    reload();
    clr_ev();
    wait_n(64);
    chk("R8 masked first hold period", evc[0], 0);
    wait_n(300);
    chk("R8 compare resumes", int'(evc[0] > 0), 1);
    fault = 3'b000;

    // R9 cross wiring on pair 1 with select
    cross1 = 1'b1; sel1 = 1'b1;
    clr_ev();
    wait_n(2200);
    chk("R9 pair 1 follows pair 0 drive", evc[1], 0);
    sel1 = 1'b0;
    wait_n(2200);
    cross1 = 1'b0;

    // R10 cross wiring on pair 2 with select
    cross2 = 1'b1; sel2 = 1'b1;
    clr_ev();
    wait_n(2200);
    chk("R10 pair 2 follows pair 0 drive", evc[2], 0);
    sel2 = 1'b0;
    wait_n(2200);
    cross2 = 1'b0;

    // R6 disable pair 2 with a fault on it
    en = 3'b011; fault = 3'b100;
    wait_n(2);
    chk("R6 disabled pair drives low", int'(drive[2]), 0);
    clr_ev();
    wait_n(700);
    chk("R6 disabled pair silent", evc[2], 0);
    fault = 3'b000; en = 3'b111;

    // R3 zero seed replaced by fallback constant
    seed = 32'h0; replay = 1'b1;
    reload();
    wait_n(4300);
    replay = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule